// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Shared Clock Divider

This block produces eight independent pulse-width modulated outputs from one system clock. A shared divider chain makes thirteen count enables: eleven power-of-two divisions of the system clock and two programmable linear dividers, each fed from one of the power-of-two stages. Every channel picks one of these enables, advances its own 20-bit counter on it, and compares the count with its duty value to form the waveform.

Software drives the block through a single-cycle register write port. Each channel has a mode word (clock selection, alignment, output polarity), a duty word and a period word. Duty and period are double-buffered so that a running waveform never shows a partly updated cycle. Channels are started and stopped through a set-style and a clear-style enable word. Each channel raises a one-cycle pulse at the end of each of its periods.

Top module: `pwm_multi`

## Requirements
- R1: After reset every channel is disabled, every output is low, and every mode, duty, period and divider setting is zero (clock select 0, left-aligned, polarity 0, divider factors 0).
- R2: Clock select values 0 to 10 give one count step every 2^sel system clocks, occurring in the cycles where the number of clocks since reset, modulo 2^sel, equals 2^sel-1; value 11 selects linear divider A, 12 selects divider B, and 13 to 15 select no step, so the counter freezes.
- R3: The divider word at address 0x00 holds divider A's factor in bits [7:0] and source stage in bits [11:8], and divider B's factor in bits [23:16] and source in bits [27:24]; a divider emits one step per factor source steps, a factor of 0 or a source above 10 emits none, and writing the word restarts both dividers.
- R4: Writing address 0x01 enables each channel whose bit in wr_data[7:0] is one (bit i is channel i); writing address 0x02 disables each channel whose bit is one; zero bits leave that channel unchanged.
- R5: A disabled channel holds its counter at zero, drives its idle level and raises no period-end pulse.
- R6: In left-aligned mode the counter steps 0,1,...,P-1 and wraps to 0; the period-end output is high for one cycle right after the wrapping step; with P of 0 or 1 every step ends a period.
- R7: In center-aligned mode the counter steps from 0 up to P and back down to 0, a period of 2P steps, and the period-end pulse follows the step that returns it to 0.
- R8: While a channel is enabled, writes to its duty (channel base + 1) and period (channel base + 2) take effect only at the end of the period in progress; while it is disabled they take effect by the next cycle.
- R9: Mode bit 9 sets polarity: with 0 the idle level is low and the active level high; with 1 both are inverted.
- R10: Channel n's words lie at word address 4+n (byte addresses 0x10+4n to 0x13+4n); the mode word (offset 0) carries clock select in bits [3:0] and center alignment in bit 8 and takes effect on the next cycle; writes to offset 3 or to any other unlisted address change nothing.
- R11: The output is at the active level exactly while the counter is below the duty value, so a duty of zero keeps the output idle and a duty at or above the period keeps a left-aligned output active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | 8 | Waveform output, one bit per channel |
| period_end_o | output | 8 | One-cycle end-of-period pulse, one bit per channel |

## Verification
On every cycle the assertions hold each counter within its active period, keep the active duty and period frozen between period ends of a running channel, tie each period-end pulse to a zero count, keep each divider counter below its factor, and require that an enable only appears after a matching set write. Waveform shape, the timing of the clock steps, the point at which buffered values are taken up, and the absence of effect of unmapped writes can only be shown by the bench's scenarios, which compare every output on every cycle against a behavioural model and count pulses and active cycles over fixed windows.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NPRESC = 11;
  localparam int NDIV   = 2;
  localparam int NTICK  = NPRESC + NDIV;
  localparam int SEL_W  = 4;
  localparam int AW     = 8;

  localparam logic [AW-1:0] A_DIVCFG = 8'h00;
  localparam logic [AW-1:0] A_EN_SET = 8'h01;
  localparam logic [AW-1:0] A_EN_CLR = 8'h02;
  localparam logic [AW-3:0] CH_WBASE = 6'h04;
  localparam logic [1:0]    OFS_MODE = 2'd0;
  localparam logic [1:0]    OFS_DUTY = 2'd1;
  localparam logic [1:0]    OFS_PER  = 2'd2;

  localparam int MODE_CENTER_BIT = 8;
  localparam int MODE_INV_BIT    = 9;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             center;
    logic             inv;
  } ch_mode_t;
endpackage

// File: rtl/pwm_lindiv.sv
module pwm_lindiv import pwm_pkg::*; #(
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DIVW-1:0]   cfg_fac,
  input  logic [SEL_W-1:0]  cfg_src,
  input  logic [NPRESC-1:0] src_ticks,
  output logic              tick_o
);
  logic [DIVW-1:0]  fac_q;
  logic [DIVW-1:0]  cnt_q, cnt_d;
  logic [SEL_W-1:0] src_q;
  logic             src_tick;
  logic             at_last;

  always_comb begin
    src_tick = 1'b0;
    for (int i = 0; i < NPRESC; i++) begin
      if (src_q == SEL_W'(i)) src_tick = src_ticks[i];
    end
  end

  assign at_last = (fac_q != '0) && (cnt_q == fac_q - DIVW'(1));
  assign tick_o  = src_tick && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (cfg_we) begin
      cnt_d = '0;
    end else if (src_tick && (fac_q != '0)) begin
      cnt_d = at_last ? '0 : cnt_q + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fac_q <= '0;
      src_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cfg_we) begin
        fac_q <= cfg_fac;
        src_q <= cfg_src;
      end
    end
  end

  assert_div_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fac_q != '0) |-> (cnt_q < fac_q));
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen import pwm_pkg::*; #(
  parameter int DIVW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [NDIV*DIVW-1:0]  cfg_fac,
  input  logic [NDIV*SEL_W-1:0] cfg_src,
  output logic [NTICK-1:0]      ticks_o
);
  localparam int PW = NPRESC - 1;

  logic [PW-1:0]     presc_q, presc_d;
  logic [NPRESC-1:0] presc_ticks;
  logic [NDIV-1:0]   div_ticks;

  assign presc_d = presc_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  assign presc_ticks[0] = 1'b1;
  for (genvar k = 1; k < NPRESC; k++) begin : g_stage
    assign presc_ticks[k] = &presc_q[k-1:0];
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    pwm_lindiv #(.DIVW(DIVW)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_fac   (cfg_fac[g*DIVW +: DIVW]),
      .cfg_src   (cfg_src[g*SEL_W +: SEL_W]),
      .src_ticks (presc_ticks),
      .tick_o    (div_ticks[g])
    );
  end

  assign ticks_o = {div_ticks, presc_ticks};
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan import pwm_pkg::*; #(
  parameter int CW = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             mode_we,
  input  ch_mode_t         mode_wd,
  input  logic             duty_we,
  input  logic             per_we,
  input  logic [CW-1:0]    val_wd,
  input  logic [NTICK-1:0] ticks_i,
  output logic             pwm_o,
  output logic             pend_o
);
  ch_mode_t      mode_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;
  logic [CW-1:0] per_u_q, duty_u_q;
  logic [CW-1:0] per_a_q, per_a_d;
  logic [CW-1:0] duty_a_q, duty_a_d;
  logic          pend_q;
  logic          tick;
  logic          bnd;
  logic [CW:0]   cnt_inc;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NTICK; i++) begin
      if (mode_q.sel == SEL_W'(i)) tick = ticks_i[i];
    end
  end

  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);

  always_comb begin
    cnt_d    = cnt_q;
    up_d     = up_q;
    per_a_d  = per_a_q;
    duty_a_d = duty_a_q;
    bnd      = 1'b0;
    if (!en_i) begin
      cnt_d    = '0;
      up_d     = 1'b1;
      per_a_d  = per_u_q;
      duty_a_d = duty_u_q;
    end else if (tick) begin
      if (per_a_q == '0) begin
        cnt_d = '0;
        up_d  = 1'b1;
        bnd   = 1'b1;
      end else if (!mode_q.center) begin
        up_d = 1'b1;
        if (cnt_q >= per_a_q - CW'(1)) begin
          cnt_d = '0;
          bnd   = 1'b1;
        end else begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end else if (up_q) begin
        cnt_d = cnt_inc[CW-1:0];
        if (cnt_inc >= {1'b0, per_a_q}) up_d = 1'b0;
      end else begin
        if (cnt_q <= CW'(1)) begin
          cnt_d = '0;
          up_d  = 1'b1;
          bnd   = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      if (bnd) begin
        per_a_d  = per_u_q;
        duty_a_d = duty_u_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cnt_q    <= '0;
      up_q     <= 1'b1;
      per_u_q  <= '0;
      duty_u_q <= '0;
      per_a_q  <= '0;
      duty_a_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      up_q     <= up_d;
      per_a_q  <= per_a_d;
      duty_a_q <= duty_a_d;
      pend_q   <= bnd;
      if (mode_we) mode_q   <= mode_wd;
      if (per_we)  per_u_q  <= val_wd;
      if (duty_we) duty_u_q <= val_wd;
    end
  end

  assign pwm_o  = en_i ? ((cnt_q < duty_a_q) ^ mode_q.inv) : mode_q.inv;
  assign pend_o = pend_q;

  assert_cnt_within_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_a_q);

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !bnd) |=> ($stable(per_a_q) && $stable(duty_a_q)));

  assert_pend_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q == '0));

  assert_off_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi import pwm_pkg::*; #(
  parameter int NCH  = 8,
  parameter int CW   = 20,
  parameter int DIVW = 8,
  parameter int DW   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] period_end_o
);
  localparam int DIV_STRIDE = DW / NDIV;

  logic [NCH-1:0]        en_q, en_d;
  logic                  set_hit, clr_hit, div_hit;
  logic [NTICK-1:0]      ticks;
  logic [NDIV*DIVW-1:0]  div_fac;
  logic [NDIV*SEL_W-1:0] div_src;
  ch_mode_t              mode_wd;

  assign set_hit = wr_en && (wr_addr == A_EN_SET);
  assign clr_hit = wr_en && (wr_addr == A_EN_CLR);
  assign div_hit = wr_en && (wr_addr == A_DIVCFG);

  always_comb begin
    en_d = en_q;
    if (set_hit) en_d = en_d | wr_data[NCH-1:0];
    if (clr_hit) en_d = en_d & ~wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_divcfg
    assign div_fac[g*DIVW +: DIVW]   = wr_data[g*DIV_STRIDE +: DIVW];
    assign div_src[g*SEL_W +: SEL_W] = wr_data[g*DIV_STRIDE + 8 +: SEL_W];
  end

  pwm_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (div_hit),
    .cfg_fac (div_fac),
    .cfg_src (div_src),
    .ticks_o (ticks)
  );

  assign mode_wd.sel    = wr_data[SEL_W-1:0];
  assign mode_wd.center = wr_data[MODE_CENTER_BIT];
  assign mode_wd.inv    = wr_data[MODE_INV_BIT];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_hit;
    assign ch_hit = wr_en && (wr_addr[AW-1:2] == CH_WBASE + (AW-2)'(i));

    pwm_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_q[i]),
      .mode_we (ch_hit && (wr_addr[1:0] == OFS_MODE)),
      .mode_wd (mode_wd),
      .duty_we (ch_hit && (wr_addr[1:0] == OFS_DUTY)),
      .per_we  (ch_hit && (wr_addr[1:0] == OFS_PER)),
      .val_wd  (wr_data[CW-1:0]),
      .ticks_i (ticks),
      .pwm_o   (pwm_o[i]),
      .pend_o  (period_end_o[i])
    );

    assert_en_needs_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[i]) |-> ($past(set_hit) && $past(wr_data[i])));
  end
endmodule

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb;
  localparam int NCH = 8;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [NCH-1:0] pwm_o;
  logic [NCH-1:0] period_end_o;

  int checks;
  int fails;
  bit done;

  pwm_multi u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pwm_o        (pwm_o),
    .period_end_o (period_end_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference model
  int  m_pc;
  int  m_fac [2];
  int  m_src [2];
  int  m_dc  [2];
  bit  m_en  [NCH];
  int  m_sel [NCH];
  bit  m_ctr [NCH];
  bit  m_pol [NCH];
  int  m_pu  [NCH];
  int  m_du  [NCH];
  int  m_pa  [NCH];
  int  m_da  [NCH];
  int  m_cnt [NCH];
  bit  m_up  [NCH];
  bit  m_pe  [NCH];
  bit  m_tk  [13];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0;
      for (int d = 0; d < 2; d++) begin m_fac[d] = 0; m_src[d] = 0; m_dc[d] = 0; end
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_sel[c] = 0; m_ctr[c] = 0; m_pol[c] = 0;
        m_pu[c] = 0; m_du[c] = 0; m_pa[c] = 0; m_da[c] = 0;
        m_cnt[c] = 0; m_up[c] = 1; m_pe[c] = 0;
      end
    end else begin
      for (int k = 0; k < 11; k++) m_tk[k] = ((m_pc % (1 << k)) == ((1 << k) - 1));
      for (int d = 0; d < 2; d++) begin
        bit st;
        st = (m_src[d] <= 10) ? m_tk[m_src[d]] : 1'b0;
        m_tk[11+d] = st && (m_fac[d] != 0) && (m_dc[d] == m_fac[d] - 1);
        if (wr_en && wr_addr == 8'h00) begin
          m_dc[d] = 0;
          m_fac[d] = (wr_data >> (16*d)) & 32'hFF;
          m_src[d] = (wr_data >> (16*d + 8)) & 32'hF;
        end else if (st && m_fac[d] != 0) begin
          m_dc[d] = (m_dc[d] == m_fac[d] - 1) ? 0 : m_dc[d] + 1;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        bit tk;
        bit b;
        tk = (m_sel[c] <= 12) ? m_tk[m_sel[c]] : 1'b0;
        b = 0;
        if (!m_en[c]) begin
          m_cnt[c] = 0; m_up[c] = 1; m_pa[c] = m_pu[c]; m_da[c] = m_du[c];
        end else if (tk) begin
          if (m_pa[c] == 0) begin
            m_cnt[c] = 0; m_up[c] = 1; b = 1;
          end else if (!m_ctr[c]) begin
            m_up[c] = 1;
            if (m_cnt[c] + 1 >= m_pa[c]) begin m_cnt[c] = 0; b = 1; end
            else m_cnt[c] = m_cnt[c] + 1;
          end else if (m_up[c]) begin
            m_cnt[c] = m_cnt[c] + 1;
            if (m_cnt[c] >= m_pa[c]) m_up[c] = 0;
          end else begin
            if (m_cnt[c] <= 1) begin m_cnt[c] = 0; m_up[c] = 1; b = 1; end
            else m_cnt[c] = m_cnt[c] - 1;
          end
          if (b) begin m_pa[c] = m_pu[c]; m_da[c] = m_du[c]; end
        end
        m_pe[c] = b;
      end
      if (wr_en && wr_addr >= 8'h10 && wr_addr < 8'h10 + 4*NCH) begin
        int c;
        c = (wr_addr - 8'h10) / 4;
        case (wr_addr % 4)
          0: begin m_sel[c] = wr_data[3:0]; m_ctr[c] = wr_data[8]; m_pol[c] = wr_data[9]; end
          1: m_du[c] = wr_data[19:0];
          2: m_pu[c] = wr_data[19:0];
          default: ;
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && wr_addr == 8'h01 && wr_data[c]) m_en[c] = 1;
        if (wr_en && wr_addr == 8'h02 && wr_data[c]) m_en[c] = 0;
      end
      m_pc = (m_pc + 1) % 1024;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        bit exp_o;
        exp_o = m_en[c] ? ((m_cnt[c] < m_da[c]) ^ m_pol[c]) : m_pol[c];
        checks++;
        if (pwm_o[c] !== exp_o) begin
          fails++;
          $display("FAIL %s ch%0d pwm_o actual=%b expected=%b", m_ctr[c] ? "R7" : "R6",
                   c, pwm_o[c], exp_o);
        end
        checks++;
        if (period_end_o[c] !== m_pe[c]) begin
          fails++;
          $display("FAIL %s ch%0d period_end_o actual=%b expected=%b", m_ctr[c] ? "R7" : "R6",
                   c, period_end_o[c], m_pe[c]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  int np [NCH];
  int nh [NCH];

  task automatic count_all(input int ncyc);
    for (int c = 0; c < NCH; c++) begin np[c] = 0; nh[c] = 0; end
    repeat (ncyc) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        np[c] += period_end_o[c];
        nh[c] += pwm_o[c];
      end
    end
  endtask

  task automatic cycles_to_pulse(input int c, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_end_o[c] && n < 500);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(pwm_o == '0, "R1 outputs after reset", pwm_o, 0);
    check(period_end_o == '0, "R1 pulses after reset", period_end_o, 0);

    // ch0 left, every clock, P=4 D=2
    wr(8'h10, 32'h0); wr(8'h11, 2); wr(8'h12, 4);
    // ch1 center, every 2 clocks, P=3 D=1
    wr(8'h14, 32'h101); wr(8'h15, 1); wr(8'h16, 3);
    // ch2 inverted, P=5 D=5
    wr(8'h18, 32'h200); wr(8'h19, 5); wr(8'h1A, 5);
    @(negedge clk);
    check(pwm_o[2] == 1'b1, "R9 disabled inverted idle", pwm_o[2], 1);
    check(pwm_o[0] == 1'b0, "R5 disabled idle low", pwm_o[0], 0);
    // dividers: A from stage 2 factor 3, B factor 0
    wr(8'h00, (32'd5 << 24) | (32'd2 << 8) | 32'd3);
    wr(8'h1C, 11); wr(8'h1D, 1); wr(8'h1E, 2);
    wr(8'h20, 12); wr(8'h21, 1); wr(8'h22, 2);
    wr(8'h24, 13); wr(8'h25, 1); wr(8'h26, 2);
    wr(8'h28, 0);  wr(8'h29, 0); wr(8'h2A, 3);
    wr(8'h2C, 4);  wr(8'h2D, 1); wr(8'h2E, 2);
    wr(8'h01, 32'h0F);
    wr(8'h01, 32'hF0);
    repeat (40) @(posedge clk);
    count_all(96);
    check(np[0] == 24, "R6 ch0 pulses", np[0], 24);
    check(nh[0] == 48, "R6 ch0 active cycles", nh[0], 48);
    check(np[1] == 8,  "R7 ch1 pulses", np[1], 8);
    check(nh[1] == 16, "R7 ch1 active cycles", nh[1], 16);
    check(nh[2] == 0,  "R11 ch2 full duty inverted", nh[2], 0);
    check(np[3] == 4,  "R3 ch3 divider A pulses", np[3], 4);
    check(np[4] == 0,  "R3 ch4 divider B off pulses", np[4], 0);
    check(nh[4] == 96, "R3 ch4 frozen active", nh[4], 96);
    check(np[5] == 0,  "R2 ch5 no clock", np[5], 0);
    check(np[6] == 32, "R6 ch6 pulses", np[6], 32);
    check(nh[6] == 0,  "R11 ch6 zero duty", nh[6], 0);
    check(np[7] == 3,  "R2 ch7 stage 4 pulses", np[7], 3);

    // double buffer while running
    cycles_to_pulse(0, n);
    wr(8'h12, 8);
    cycles_to_pulse(0, n);
    check(n == 3, "R8 old period completes", n, 3);
    cycles_to_pulse(0, n);
    check(n == 8, "R8 new period applied", n, 8);

    // disable, rewrite, re-enable
    wr(8'h02, 32'h01);
    @(negedge clk);
    check(pwm_o[0] == 1'b0, "R5 cleared channel idle", pwm_o[0], 0);
    count_all(16);
    check(np[0] == 0, "R4 cleared channel no pulses", np[0], 0);
    wr(8'h11, 1); wr(8'h12, 2);
    wr(8'h01, 32'h01);
    repeat (4) @(posedge clk);
    count_all(16);
    check(np[0] == 8, "R8 disabled write direct", np[0], 8);
    check(nh[0] == 8, "R6 ch0 new duty", nh[0], 8);

    // clear only ch1
    wr(8'h02, 32'h02);
    repeat (2) @(posedge clk);
    count_all(24);
    check(np[1] == 0 && nh[1] == 0, "R4 ch1 stopped", np[1] + nh[1], 0);
    check(np[0] == 12, "R4 ch0 untouched", np[0], 12);

    // unmapped writes
    wr(8'h7F, 32'hFFFFFFFF); wr(8'h03, 32'hFFFFFFFF); wr(8'h13, 32'hFFFFFFFF);
    count_all(16);
    check(np[0] == 8, "R10 unmapped writes ignored", np[0], 8);

    // mode change takes effect
    wr(8'h10, 13);
    count_all(16);
    check(np[0] == 0, "R10 mode select freezes", np[0], 0);

    done = 1;
    summary();
    $finish;
  end
endmodule